// File: doc/BRIEF.md
# Codec Command Slot Interface

This block gives software access to the control registers of an audio codec through two transmit slot registers: a data slot and a command slot. Software first places the write data in the data slot, then writes the command slot. The command word holds a read flag and a 7-bit register index. A write updates an internal bank of 16-bit codec registers. A read copies the selected register into two receive slot registers and raises valid flags. A status register reports whether each transmit slot is empty, whether a read is still busy, and whether the receive slots hold valid results. The serial framing onto the codec link is not part of this block.

Every register sits on a simple strobe bus with a 3-bit register select. Reads return data one clock after the strobe. The register map is:

| Select | Register |
|---|---|
| 0 | command slot |
| 1 | data slot |
| 2 | receive command |
| 3 | receive data |
| 4 | status |

Any other select reads as zero and ignores writes.

A small sequencer runs each access. It has three states:

- `ST_IDLE` waits for a command.
- `ST_WRITE` commits a write to the bank.
- `ST_READ` loads the receive slots.

It has three transitions:

- IDLE→WRITE is taken on an accepted command with the read flag clear.
- IDLE→READ is taken on an accepted command with the read flag set.
- WRITE→IDLE and READ→IDLE are taken unconditionally after one cycle.

Top module: `codec_cmd_slot`

## Requirements
- R1: After reset, status reads 0x00007. Bit 0 is command-empty, bit 1 is data-empty and bit 2 is combined-empty. Busy bits 3–4 and valid bits 5–6 are clear, and both receive registers read 0.
- R2: Writing select 1 stores the 20-bit data slot, which reads back unchanged. From the next cycle, status bits 1 and 2 are clear. The bank write data is slot bits 19:4; bits 3:0 are ignored.
- R3: A write to select 0 in `ST_IDLE` is stored and clears status bits 0 and 2. Bit 19 selects read (1) or write (0), and bits 18:12 give the register index. The access completes on the following clock edge, when the sequencer returns to `ST_IDLE`. A command write in any other state is ignored.
- R4: A write command stores data slot bits 19:4 into the bank register at the index. This happens only when the index is even and index/2 < BANK_WORDS; other indices are left without effect.
- R5: A read command loads the receive command register with the command word with bit 19 cleared. It loads the receive data register with the bank value shifted left by 4 (bits 3:0 zero). An unimplemented index reads as value 0.
- R6: Accepting a read command sets status bits 3 and 4 (busy). Completing the read clears them and sets bits 5 and 6 (valid).
- R7: A bus read of select 3 (receive data) clears status bits 5 and 6. A bus read of select 2 does not clear them.
- R8: Bus read data is registered and appears one cycle after the read strobe. Selects 5–7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 20 | Write data |
| bus_rdata | output | 20 | Registered read data |

## Verification
A transmit slot write shows in status from the cycle after its strobe. A command completes on the next edge, so its receive registers and valid bits are visible to a read strobe issued two cycles after the command strobe. Read data is taken at the falling edge after the read strobe's rising edge. The bench therefore inserts one idle cycle after each command. It deliberately reads status in the gap cycle to catch the busy bits, then reads the receive registers and status afterwards. A near-exhaustive sweep writes and reads back all 128 indices against a bank of 16 words, with expected values computed from the index.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    localparam int SLOT_W     = 20;
    localparam int IDX_W      = 7;
    localparam int VAL_W      = 16;
    localparam int PAD_W      = 4;
    localparam int RD_FLAG    = 19;
    localparam int IDX_LSB    = 12;
    localparam int SEL_W      = 3;
    localparam int STAT_W     = 7;

    localparam int ST_CMD_EMPTY  = 0;
    localparam int ST_DATA_EMPTY = 1;
    localparam int ST_ALL_EMPTY  = 2;
    localparam int ST_RXC_BUSY   = 3;
    localparam int ST_RXD_BUSY   = 4;
    localparam int ST_RXC_VALID  = 5;
    localparam int ST_RXD_VALID  = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } seq_state_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD_TX  = 3'd0,
        SEL_DATA_TX = 3'd1,
        SEL_CMD_RX  = 3'd2,
        SEL_DATA_RX = 3'd3,
        SEL_STATUS  = 3'd4
    } bus_sel_t;
endpackage

// File: rtl/ccs_bank.sv
module ccs_bank
    import ccs_pkg::*;
#(
    parameter int BANK_WORDS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [VAL_W-1:0] wval,
    output logic [VAL_W-1:0] rval
);
    localparam int WSEL_W = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1;

    logic [IDX_W-2:0] half;
    logic             hit;
    logic [VAL_W-1:0] word_q [BANK_WORDS];

    assign half = idx[IDX_W-1:1];
    assign hit  = !idx[0] && (int'(half) < BANK_WORDS);

    for (genvar g = 0; g < BANK_WORDS; g++) begin : g_word
        logic sel_g;
        assign sel_g = we && hit && (int'(half) == g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (sel_g) begin
                word_q[g] <= wval;
            end
        end

        AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!we || idx != IDX_W'(2*g)) |=> $stable(word_q[g])) else $error("word changed"); // R4
    end

    always_comb begin
        rval = '0;
        for (int i = 0; i < BANK_WORDS; i++) begin
            if (hit && int'(half) == i) begin
                rval = word_q[i];
            end
        end
    end

    logic [WSEL_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/ccs_fsm.sv
module ccs_fsm
    import ccs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_accept,
    input  logic rd_flag,
    output logic idle,
    output logic do_write,
    output logic do_read
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_accept) begin
                    state_d = rd_flag ? ST_READ : ST_WRITE;
                end
            end
            ST_WRITE: state_d = ST_IDLE;
            ST_READ:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        do_write = 1'b0;
        do_read  = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle     = 1'b1;
            ST_WRITE: do_write = 1'b1;
            ST_READ:  do_read  = 1'b1;
            default:  idle     = 1'b1;
        endcase
    end

    AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE)) else $error("exec stuck"); // R3
    AST_ACCEPT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && rd_flag) |=> do_read) else $error("read not started"); // R3
    AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_write, do_read, idle}) && (idle || do_write || do_read)) else $error("state decode"); // R4
endmodule

// File: rtl/ccs_regs.sv
module ccs_regs
    import ccs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [SLOT_W-1:0] bus_wdata,
    output logic [SLOT_W-1:0] bus_rdata,
    input  logic              idle,
    input  logic              do_read,
    input  logic [VAL_W-1:0]  bank_rval,
    output logic              cmd_accept,
    output logic [SLOT_W-1:0] cmd_q,
    output logic [SLOT_W-1:0] data_q
);
    bus_sel_t          sel;
    logic              data_we, valid_clr;
    logic [SLOT_W-1:0] rx_cmd_q, rx_data_q, rdata_q, rd_mux;
    logic [STAT_W-1:0] stat_q;

    assign sel        = bus_sel_t'(bus_sel);
    assign cmd_accept = bus_wr && sel == SEL_CMD_TX && idle;
    assign data_we    = bus_wr && sel == SEL_DATA_TX;
    assign valid_clr  = bus_rd && sel == SEL_DATA_RX;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            data_q    <= '0;
            rx_cmd_q  <= '0;
            rx_data_q <= '0;
            stat_q    <= STAT_W'((1 << ST_CMD_EMPTY) | (1 << ST_DATA_EMPTY) | (1 << ST_ALL_EMPTY));
        end else begin
            if (data_we) begin
                data_q                <= bus_wdata;
                stat_q[ST_DATA_EMPTY] <= 1'b0;
                stat_q[ST_ALL_EMPTY]  <= 1'b0;
            end
            if (cmd_accept) begin
                cmd_q                <= bus_wdata;
                stat_q[ST_CMD_EMPTY] <= 1'b0;
                stat_q[ST_ALL_EMPTY] <= 1'b0;
                if (bus_wdata[RD_FLAG]) begin
                    stat_q[ST_RXC_BUSY] <= 1'b1;
                    stat_q[ST_RXD_BUSY] <= 1'b1;
                end
            end
            if (do_read) begin
                rx_cmd_q             <= {1'b0, cmd_q[SLOT_W-2:0]};
                rx_data_q            <= {bank_rval, {PAD_W{1'b0}}};
                stat_q[ST_RXC_BUSY]  <= 1'b0;
                stat_q[ST_RXD_BUSY]  <= 1'b0;
                stat_q[ST_RXC_VALID] <= 1'b1;
                stat_q[ST_RXD_VALID] <= 1'b1;
            end else if (valid_clr) begin
                stat_q[ST_RXC_VALID] <= 1'b0;
                stat_q[ST_RXD_VALID] <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CMD_TX:  rd_mux = cmd_q;
            SEL_DATA_TX: rd_mux = data_q;
            SEL_CMD_RX:  rd_mux = rx_cmd_q;
            SEL_DATA_RX: rd_mux = rx_data_q;
            SEL_STATUS:  rd_mux = SLOT_W'(stat_q);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

    AST_CMD_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> (!stat_q[ST_CMD_EMPTY] && !stat_q[ST_ALL_EMPTY])) else $error("cmd empty"); // R3
    AST_DATA_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> (!stat_q[ST_DATA_EMPTY] && !stat_q[ST_ALL_EMPTY])) else $error("data empty"); // R2
    AST_BUSY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && bus_wdata[RD_FLAG]) |=> (stat_q[ST_RXC_BUSY] && stat_q[ST_RXD_BUSY])) else $error("busy"); // R6
    AST_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        do_read |=> (stat_q[ST_RXC_VALID] && stat_q[ST_RXD_VALID] && !stat_q[ST_RXC_BUSY] && !stat_q[ST_RXD_BUSY])) else $error("done"); // R6
    AST_RX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        do_read |=> (!rx_cmd_q[RD_FLAG] && rx_data_q[PAD_W-1:0] == '0)) else $error("echo"); // R5
    AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_clr && !do_read) |=> (!stat_q[ST_RXC_VALID] && !stat_q[ST_RXD_VALID])) else $error("valid clr"); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)) else $error("rdata moved"); // R8
endmodule

// File: rtl/codec_cmd_slot.sv
module codec_cmd_slot
    import ccs_pkg::*;
#(
    parameter int BANK_WORDS = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [2:0]             bus_sel,
    input  logic [19:0]            bus_wdata,
    output logic [19:0]            bus_rdata
);
    logic              idle, do_write, do_read, cmd_accept;
    logic [SLOT_W-1:0] cmd_q, data_q;
    logic [VAL_W-1:0]  bank_rval;

    ccs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_accept (cmd_accept),
        .rd_flag    (bus_wdata[RD_FLAG]),
        .idle       (idle),
        .do_write   (do_write),
        .do_read    (do_read)
    );

    ccs_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_sel    (bus_sel),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .idle       (idle),
        .do_read    (do_read),
        .bank_rval  (bank_rval),
        .cmd_accept (cmd_accept),
        .cmd_q      (cmd_q),
        .data_q     (data_q)
    );

    ccs_bank #(.BANK_WORDS(BANK_WORDS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_write),
        .idx   (cmd_q[IDX_LSB +: IDX_W]),
        .wval  (data_q[PAD_W +: VAL_W]),
        .rval  (bank_rval)
    );
endmodule

// File: tb/tb_codec_cmd_slot.sv
module tb_codec_cmd_slot;
    localparam int WORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [19:0] bus_wdata = '0;
    logic [19:0] bus_rdata;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    codec_cmd_slot #(.BANK_WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string what, input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %05h expected %05h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [19:0] d);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [19:0] d);
        bus_rd = 1'b1; bus_sel = s;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] pat(input int idx);
        return 16'((idx * 517 + 16'h1234) & 16'hFFFF);
    endfunction

    function automatic logic [15:0] expect_val(input int idx);
        if ((idx % 2) == 0 && (idx / 2) < WORDS) return pat(idx);
        return 16'h0;
    endfunction

    initial begin
        logic [19:0] v;
        logic [19:0] cmd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(3'd4, v); check("R1 reset status", v, 20'h00007);
        rd(3'd2, v); check("R1 reset rx cmd", v, 20'h0);
        rd(3'd3, v); check("R1 reset rx data", v, 20'h0);
        rd(3'd6, v); check("R8 unmapped select", v, 20'h0);

        // R2 data slot write and readback
        wr(3'd1, {pat(0), 4'hF});
        rd(3'd4, v); check("R2 status after data write", v, 20'h00001);
        rd(3'd1, v); check("R2 data slot readback", v, {pat(0), 4'hF});

        // R4 write sweep over every index, low nibble junk
        for (int i = 0; i < 128; i++) begin
            wr(3'd1, {pat(i), 4'(i)});
            wr(3'd0, {1'b0, 7'(i), 12'hABC});
            @(negedge clk);
            if (i == 0) begin
                rd(3'd4, v); check("R3 status after cmd write", v, 20'h00000);
                rd(3'd0, v); check("R3 cmd slot readback", v, {1'b0, 7'd0, 12'hABC});
            end
        end

        // R5 R6 R7 read sweep
        for (int i = 0; i < 128; i++) begin
            cmd = {1'b1, 7'(i), 12'(i * 3)};
            wr(3'd0, cmd);
            rd(3'd4, v); check("R6 busy during read", v, 20'h00018);
            rd(3'd2, v); check("R5 rx cmd echo", v, {1'b0, cmd[18:0]});
            rd(3'd4, v); check("R7 valid kept after rx cmd read", v, 20'h00060);
            rd(3'd3, v); check($sformatf("R4 R5 rx data idx %0d", i), v, {expect_val(i), 4'h0});
            rd(3'd4, v); check("R7 valid cleared by rx data read", v, 20'h00000);
        end

        // R3 command while executing is ignored
        wr(3'd1, {16'hDEAD, 4'h0});
        wr(3'd0, {1'b1, 7'd2, 12'h000});
        wr(3'd0, {1'b0, 7'd2, 12'h000});
        @(negedge clk);
        rd(3'd2, v); check("R3 second cmd ignored echo", v, {1'b0, 7'd2, 12'h000});
        rd(3'd3, v); check("R3 rx data from first cmd", v, {pat(2), 4'h0});
        wr(3'd0, {1'b1, 7'd2, 12'h000});
        @(negedge clk);
        rd(3'd3, v); check("R3 busy cmd did not write bank", v, {pat(2), 4'h0});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule